// File: doc/BRIEF.md
# Divided-Counter Phase-Frequency Detector

This block compares an asynchronous reference (a clock or a pulse train) with the local clock that drives it. Each side first passes through its own programmable ratio divider. Over a measurement window, the block counts the divided-reference events and subtracts the divided-feedback events. At the end of the window it presents the signed difference as an error sample for a downstream loop filter. When the loop is locked, the two divided rates match and the error settles toward zero.

The window length is set in units of an external update-enable pulse by a separate terminal count. At each window boundary the block spends one cycle in a dump state, where it raises a one-cycle strobe. The strobe hands the error to the filter, and in the same cycle all internal counters are cleared. The difference accumulator saturates instead of wrapping, and a flag reports that saturation for the window just closed. The reference reaches the counting logic through a synchronizer followed by rising-edge detection.

The control is a two-state machine with states S_MEASURE and S_DUMP. The transition S_MEASURE to S_DUMP is taken on the cycle that carries the terminating enable. The transition S_DUMP to S_MEASURE is taken unconditionally one cycle later. Reset enters S_MEASURE.

Top module: `divcnt_pfd`

## Requirements
- R1: A synchronous active-high reset clears the error to 0, the overflow flag to 0, the strobe to 0 and every counter; the block then starts in S_MEASURE.
- R2: Each rising edge of `ref_i` (held at least one clock high and one clock low) becomes exactly one reference event. The event is counted in the third rising clock edge after the edge that first samples the new level.
- R3: The reference divider emits one divided event for every `ref_ratio_i`+1 reference events. The count restarts from zero in each window, so a ratio of 0 passes every event.
- R4: The feedback divider emits one divided event for every `fb_ratio_i`+1 clock cycles spent in S_MEASURE. A ratio of 0 gives one event per cycle.
- R5: With a value N on `win_tc_i`, the window closes on the (N+1)-th cycle in S_MEASURE that has `rate_en_i` high. `strobe_o` is high for exactly the following cycle (S_DUMP). With `rate_en_i` held high, strobes therefore repeat every N+2 cycles, and with `rate_en_i` low no strobe occurs.
- R6: The error output is a two's-complement value equal to the divided-reference events minus the divided-feedback events over the window, including the closing cycle. It becomes valid in the strobe cycle and holds until the next strobe.
- R7: The difference saturates at the most positive and most negative values of the error width. If a window saturated, `ovf_o` is 1 from its strobe cycle onward.
- R8: In the S_DUMP cycle, enables and events are ignored and both dividers, the accumulator and the window counter are cleared. Consecutive windows with identical settings therefore give identical errors.
- R9: `ovf_o` reflects only the most recently closed window. It changes only in a strobe cycle and returns to 0 after a window without saturation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Local generated clock; all logic runs on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| ref_i | input | 1 | Asynchronous reference clock or pulse |
| ref_ratio_i | input | DIV_W (16) | Reference divider setting, ratio = value + 1 |
| fb_ratio_i | input | DIV_W (16) | Feedback divider setting, ratio = value + 1 |
| rate_en_i | input | 1 | Update-enable pulse counted to size the window |
| win_tc_i | input | WIN_W (16) | Window terminal count (typical 0x07FF) |
| err_o | output | ERR_W (21) | Signed error sample, valid from the strobe |
| strobe_o | output | 1 | One-cycle window-end strobe: load error, counters cleared |
| ovf_o | output | 1 | Saturation occurred in the last closed window |

## Verification
The closing of a window and a divided-feedback event can fall in the same cycle. The block must then count that event into the closing sample and not lose it to the clear. The bench provokes this by choosing a window of 40 cycles and a feedback ratio of 5, so the eighth feedback event lands exactly on the terminating cycle. Meanwhile it feeds eight reference edges, and the expected error is exactly zero; a dropped or a doubled event shows as plus or minus one. The same coincidence happens in the saturating windows, where the accumulator is pinned at a limit while the window closes. There the bench judges that the pinned value and the flag both appear in the strobe cycle.

// File: rtl/divcnt_pfd_pkg.sv
package divcnt_pfd_pkg;

    // Window controller states
    typedef enum logic [0:0] {
        S_MEASURE = 1'b0,   // counting events inside a window
        S_DUMP    = 1'b1    // strobe cycle: hand off sample, clear counters
    } win_state_e;

endpackage

// File: rtl/divcnt_pfd_edge_sync.sv
// Brings an asynchronous level into the local domain and emits one pulse
// per rising edge.
module divcnt_pfd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic async_i,
    output logic rise_o
);

    logic [STAGES-1:0] chain_q;
    logic              last_q;
    logic [STAGES:0]   chain_in;

    assign chain_in = {chain_q, async_i};

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= chain_in[STAGES-1:0];
            last_q  <= chain_q[STAGES-1];
        end
    end

    assign rise_o = chain_q[STAGES-1] & ~last_q;

    // R2: an edge pulse can never be two cycles long
    p_rise_single_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        rise_o |=> !rise_o)
        else $error("p_rise_single_r2");

endmodule

// File: rtl/divcnt_pfd_ratio_div.sv
// Event divider: one tick per (ratio+1) input events, clearable.
module divcnt_pfd_ratio_div #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         clr_i,
    input  logic         ev_i,
    input  logic [W-1:0] ratio_i,
    output logic         tick_o
);

    logic [W-1:0] cnt_q;
    logic         at_top;

    assign at_top = (cnt_q == ratio_i);
    assign tick_o = ev_i & at_top;

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) begin
            cnt_q <= '0;
        end else if (ev_i) begin
            if (at_top) cnt_q <= '0;
            else        cnt_q <= cnt_q + {{(W-1){1'b0}}, 1'b1};
        end
    end

    // R8: a clear always leaves the divider at its starting count
    p_div_clear_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        clr_i |=> (cnt_q == '0))
        else $error("p_div_clear_r8");

    // R3: after an emitted tick the divider restarts from zero
    p_div_restart_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        tick_o |=> (cnt_q == '0))
        else $error("p_div_restart_r3");

endmodule

// File: rtl/divcnt_pfd_sat_acc.sv
// Saturating signed up/down accumulator of divided events.
module divcnt_pfd_sat_acc #(
    parameter int W = 21
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                clr_i,
    input  logic                en_i,
    input  logic                up_i,
    input  logic                dn_i,
    output logic signed [W-1:0] nxt_o,
    output logic                hit_o
);

    localparam logic signed [W-1:0] TOP = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] BOT = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0]        ONE = {{(W-1){1'b0}}, 1'b1};

    logic signed [W-1:0] acc_q;

    always_comb begin
        nxt_o = acc_q;
        hit_o = 1'b0;
        if (up_i && !dn_i) begin
            if (acc_q == TOP) hit_o = 1'b1;
            else              nxt_o = acc_q + ONE;
        end else if (dn_i && !up_i) begin
            if (acc_q == BOT) hit_o = 1'b1;
            else              nxt_o = acc_q - ONE;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) acc_q <= '0;
        else if (en_i)      acc_q <= nxt_o;
    end

    // R8: the accumulator restarts at zero after a clear
    p_acc_clear_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        clr_i |=> (acc_q == '0))
        else $error("p_acc_clear_r8");

    // R7: a saturating step leaves the stored value unchanged
    p_acc_pinned_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (hit_o && en_i && !clr_i) |=> $stable(acc_q))
        else $error("p_acc_pinned_r7");

endmodule

// File: rtl/divcnt_pfd.sv
// Divided-counter phase-frequency detector, top level.
module divcnt_pfd
    import divcnt_pfd_pkg::*;
#(
    parameter int DIV_W       = 16,
    parameter int WIN_W       = 16,
    parameter int ERR_W       = 21,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic                    ref_i,
    input  logic [DIV_W-1:0]        ref_ratio_i,
    input  logic [DIV_W-1:0]        fb_ratio_i,
    input  logic                    rate_en_i,
    input  logic [WIN_W-1:0]        win_tc_i,
    output logic signed [ERR_W-1:0] err_o,
    output logic                    strobe_o,
    output logic                    ovf_o
);

    localparam logic [WIN_W-1:0] WIN_ONE = {{(WIN_W-1){1'b0}}, 1'b1};

    win_state_e state_q, state_d;

    logic                    measuring;
    logic                    dumping;
    logic                    win_end;
    logic [WIN_W-1:0]        win_cnt_q;
    logic                    ref_rise;
    logic                    ref_tick;
    logic                    fb_tick;
    logic signed [ERR_W-1:0] acc_nxt;
    logic                    acc_hit;
    logic                    sat_seen_q;
    logic signed [ERR_W-1:0] err_q;
    logic                    ovf_q;

    assign measuring = (state_q == S_MEASURE);
    assign dumping   = (state_q == S_DUMP);
    assign win_end   = measuring && rate_en_i && (win_cnt_q == win_tc_i);

    // ---------------- state register ----------------
    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= S_MEASURE;
        else       state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_MEASURE: state_d = win_end ? S_DUMP : S_MEASURE;
            S_DUMP:    state_d = S_MEASURE;
            default:   state_d = S_MEASURE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        strobe_o = 1'b0;
        unique case (state_q)
            S_MEASURE: strobe_o = 1'b0;
            S_DUMP:    strobe_o = 1'b1;
            default:   strobe_o = 1'b0;
        endcase
    end

    assign err_o = err_q;
    assign ovf_o = ovf_q;

    // ---------------- window counter ----------------
    always_ff @(posedge clk_i) begin
        if (rst_i || dumping)           win_cnt_q <= '0;
        else if (measuring && rate_en_i) win_cnt_q <= win_cnt_q + WIN_ONE;
    end

    // ---------------- sample and flag ----------------
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            err_q      <= '0;
            ovf_q      <= 1'b0;
            sat_seen_q <= 1'b0;
        end else if (dumping) begin
            sat_seen_q <= 1'b0;
        end else begin
            sat_seen_q <= sat_seen_q | acc_hit;
            if (win_end) begin
                err_q <= acc_nxt;
                ovf_q <= sat_seen_q | acc_hit;
            end
        end
    end

    // ---------------- datapath ----------------
    divcnt_pfd_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) u_ref_sync (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .async_i (ref_i),
        .rise_o  (ref_rise)
    );

    divcnt_pfd_ratio_div #(
        .W (DIV_W)
    ) u_ref_div (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .clr_i   (dumping),
        .ev_i    (ref_rise & measuring),
        .ratio_i (ref_ratio_i),
        .tick_o  (ref_tick)
    );

    divcnt_pfd_ratio_div #(
        .W (DIV_W)
    ) u_fb_div (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .clr_i   (dumping),
        .ev_i    (measuring),
        .ratio_i (fb_ratio_i),
        .tick_o  (fb_tick)
    );

    divcnt_pfd_sat_acc #(
        .W (ERR_W)
    ) u_acc (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .clr_i (dumping),
        .en_i  (measuring),
        .up_i  (ref_tick),
        .dn_i  (fb_tick),
        .nxt_o (acc_nxt),
        .hit_o (acc_hit)
    );

    // ---------------- assertions ----------------
    // R5: the strobe lasts exactly one cycle
    p_strobe_pulse_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        strobe_o |=> !strobe_o)
        else $error("p_strobe_pulse_r5");

    // R6: the error sample changes only together with the strobe
    p_err_hold_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        !strobe_o |-> $stable(err_o))
        else $error("p_err_hold_r6");

    // R9: the overflow flag changes only together with the strobe
    p_ovf_hold_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        !strobe_o |-> $stable(ovf_o))
        else $error("p_ovf_hold_r9");

    // R8: the dump state lasts one cycle and no divided event occurs in it
    p_dump_quiet_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        dumping |-> (!ref_tick && !fb_tick))
        else $error("p_dump_quiet_r8");

endmodule

// File: tb/test_divcnt_pfd.sv
module test_divcnt_pfd;

    localparam int EW = 8;

    typedef struct packed {
        logic [15:0]        tc;
        logic [15:0]        rr;
        logic [15:0]        fr;
        logic [15:0]        nref;
        logic signed [15:0] exp_err;
        logic               exp_ovf;
    } vec_t;

    // Each row: window tc, ref ratio, fb ratio, reference edges, expected error, expected flag
    localparam vec_t VECS [10] = '{
        '{16'd39,  16'd0, 16'd65535, 16'd5,   16'sd5,    1'b0}, // R2 R3: 5 edges pass
        '{16'd39,  16'd1, 16'd65535, 16'd5,   16'sd2,    1'b0}, // R3: divide by 2
        '{16'd39,  16'd0, 16'd3,     16'd0,  -16'sd10,   1'b0}, // R4: 40 cycles / 4
        '{16'd39,  16'd0, 16'd4,     16'd8,   16'sd0,    1'b0}, // R6: lock, fb tick on closing cycle
        '{16'd59,  16'd2, 16'd9,     16'd12, -16'sd2,    1'b0}, // R3 R4 R6: 4 - 6
        '{16'd199, 16'd0, 16'd0,     16'd0,  -16'sd128,  1'b1}, // R7: negative limit
        '{16'd299, 16'd0, 16'd65535, 16'd130, 16'sd127,  1'b1}, // R7: positive limit
        '{16'd39,  16'd0, 16'd65535, 16'd5,   16'sd5,    1'b0}, // R9: flag drops again
        '{16'd39,  16'd0, 16'd6,     16'd0,  -16'sd5,    1'b0}, // R8: first window
        '{16'd39,  16'd0, 16'd6,     16'd0,  -16'sd5,    1'b0}  // R8: divider restarted
    };

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 ref_in = 1'b0;
    logic                 rate_en = 1'b1;
    logic [15:0]          rr = 16'd0;
    logic [15:0]          fr = 16'd65535;
    logic [15:0]          tc = 16'd39;
    logic signed [EW-1:0] err;
    logic                 strobe;
    logic                 ovf;

    int en_mode  = 0;   // 0: always, 1: every third cycle, 2: never
    int en_phase = 0;
    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    always @(negedge clk) begin
        en_phase <= (en_phase == 2) ? 0 : en_phase + 1;
        case (en_mode)
            0:       rate_en <= 1'b1;
            1:       rate_en <= (en_phase == 0);
            default: rate_en <= 1'b0;
        endcase
    end

    divcnt_pfd #(
        .DIV_W (16), .WIN_W (16), .ERR_W (EW), .SYNC_STAGES (2)
    ) i_divcnt_pfd (
        .clk_i       (clk),
        .rst_i       (rst),
        .ref_i       (ref_in),
        .ref_ratio_i (rr),
        .fb_ratio_i  (fr),
        .rate_en_i   (rate_en),
        .win_tc_i    (tc),
        .err_o       (err),
        .strobe_o    (strobe),
        .ovf_o       (ovf)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_strobe();
        do @(negedge clk); while (!strobe);
    endtask

    task automatic pulse_ref(input int n);
        for (int k = 0; k < n; k++) begin
            ref_in = 1'b1;
            @(negedge clk);
            ref_in = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R5 watchdog actual=hung expected=completed");
        summary();
        $finish;
    end

    initial begin
        int gap;
        int cnt;
        logic signed [EW-1:0] held;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(err == 0, "R1 err in reset", int'(err), 0);
        check(ovf == 1'b0, "R1 ovf in reset", int'(ovf), 0);
        check(strobe == 1'b0, "R1 strobe in reset", int'(strobe), 0);
        rst = 1'b0;
        wait_strobe();

        // vector table
        for (int i = 0; i < 10; i++) begin
            tc = VECS[i].tc;
            rr = VECS[i].rr;
            fr = VECS[i].fr;
            pulse_ref(int'(VECS[i].nref));
            wait_strobe();
            check(int'(err) == int'(VECS[i].exp_err), $sformatf("R6 err vector %0d", i),
                  int'(err), int'(VECS[i].exp_err));
            check(ovf == VECS[i].exp_ovf, $sformatf("R7 R9 ovf vector %0d", i),
                  int'(ovf), int'(VECS[i].exp_ovf));
        end

        // R5: strobe spacing with the enable always high
        tc = 16'd39; fr = 16'd65535; rr = 16'd0;
        gap = 0;
        do begin @(negedge clk); gap++; end while (!strobe);
        check(gap == 41, "R5 spacing tc=39", gap, 41);
        @(negedge clk);
        check(strobe == 1'b0, "R5 strobe width", int'(strobe), 0);
        wait_strobe();

        // R5: enable every third cycle, window of 5 enables
        tc = 16'd4;
        en_mode = 1;
        wait_strobe();
        gap = 0;
        do begin @(negedge clk); gap++; end while (!strobe);
        check(gap == 15, "R5 spacing gated enable", gap, 15);

        // R5 R6: no enable means no strobe and a held sample
        held = err;
        en_mode = 2;
        cnt = 0;
        for (int k = 0; k < 120; k++) begin
            @(negedge clk);
            if (strobe) cnt++;
        end
        check(cnt == 0, "R5 no strobe without enable", cnt, 0);
        check(err == held, "R6 sample held", int'(err), int'(held));
        en_mode = 0;
        tc = 16'd39;
        wait_strobe();

        // R7 then R1: saturate, then reset mid-run
        tc = 16'd199; fr = 16'd0;
        wait_strobe();
        check(ovf == 1'b1, "R7 flag before reset", int'(ovf), 1);
        check(int'(err) == -128, "R7 pinned at limit", int'(err), -128);
        rst = 1'b1;
        @(negedge clk);
        check(ovf == 1'b0, "R1 ovf after reset", int'(ovf), 0);
        check(err == 0, "R1 err after reset", int'(err), 0);
        check(strobe == 1'b0, "R1 strobe after reset", int'(strobe), 0);
        rst = 1'b0;

        summary();
        $finish;
    end

endmodule